// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Address Controller

This block is the slave-side protocol engine of a two-wire serial memory. It takes already synchronised bus events from a pin front end and decides when to pull the data line low. The events are a start pulse, a stop pulse, and a bit pulse that carries the sampled data level. The block decodes the device address byte and keeps the word address counter. It drives read and write strobes into a byte array that sits beside it, and it refuses to acknowledge its address while a write cycle is still in progress. The array has a one-cycle registered read.

Writes start with a write-mode device address, followed by a two-byte word address (high byte first) and then one or more data bytes. Each data byte is stored at the counter, and the counter advances inside the current 64-byte page only. Reads come in three forms. A current-address read starts from the counter. A random read first loads an address by sending the word address in write mode, then issues a repeated start and a read-mode device address. A sequential read continues while the master acknowledges each byte, and the counter wraps across the whole array. The data line level during a driven slot is `!sdaLowEn`. The block expects bit pulses to be at least seven clock cycles apart, so that a read fetch can complete between them.

Top module: `ee_slave_ctl`

## Requirements
- R1: A device address byte whose upper four bits are 1010 is acknowledged (sdaLowEn high in its ninth slot) when the block is not busy. Its bits 3..1 are not compared. Any other upper nibble gets no acknowledge, and the block leaves the line released for every bit until the next start or stop.
- R2: Bit 0 of the device address byte is 0 for write and 1 for read. In write mode the next two bytes are acknowledged and load the 14-bit word address: bits 5..0 of the first byte form address bits 13..8, and the second byte forms bits 7..0.
- R3: Every write-mode data byte is acknowledged and written (memWrEn for one cycle) at the counter address. The counter then increments its low six bits only, so that writing byte 63 of a page wraps the counter to byte 0 of the same page.
- R4: A stop that ends a transfer containing at least one data byte starts a busy interval of WR_CYCLES clocks. A device address byte received during this interval is not acknowledged, and the same byte is acknowledged after the interval.
- R5: After a read-mode device address is acknowledged, the byte at the counter is shifted out MSB first, with sdaLowEn equal to the inverse of each bit. The counter then increments across the whole array, so the next address after 0x3FFF is 0x0000.
- R6: A current-address read returns the byte at the address one past the last byte written or read.
- R7: A word address load followed by a repeated start and a read-mode device address reads from the loaded address, and it does not start a busy interval.
- R8: A master acknowledge (data low in the ninth slot of a read byte) continues with the next byte. A master non-acknowledge ends the read, and the block stays released for all further bits until a start or stop.
- R9: A start or a stop at any point abandons the current byte, and sdaLowEn is low in the following cycle.
- R10: After reset the counter is 0, the block is not busy, sdaLowEn is low and neither memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startEv | input | 1 | One-cycle pulse for a start or repeated start |
| stopEv | input | 1 | One-cycle pulse for a stop |
| bitEv | input | 1 | One-cycle pulse at each clock-line rising edge |
| sdaIn | input | 1 | Data line level sampled with bitEv |
| sdaLowEn | output | 1 | Pull the data line low for the current slot |
| memRdEn | output | 1 | Array read strobe; data returns next cycle |
| memWrEn | output | 1 | Array write strobe |
| memAddr | output | 14 | Array address |
| memWrData | output | 8 | Array write data |
| memRdData | input | 8 | Array read data |

## Verification
The main function is exercised with several transfer shapes. A single-byte current-address read checks the reset counter. A three-byte write that crosses a page end separates page-local wrap from whole-array wrap. A random read that runs on past a page end shows that reads, unlike writes, carry into the next page. A sequential read that starts at the last array address confirms the wrap back to zero. Address bytes sent during and after the write cycle, with a wrong device nibble, and stops inside a driven data byte separate a silent failure from a correct refusal, because each case either shows the expected pull-down or shows none.

// File: rtl/ee_ctl_pkg.sv
package ee_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic loadHi;
    logic loadAddr;
    logic incPage;
    logic incWrap;
    logic loadTx;
    logic txMode;
  } ctlStrobe_t;

endpackage

// File: rtl/ee_addr_path.sv
module ee_addr_path
  import ee_ctl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEv,
  input  logic              sdaIn,
  input  ctlStrobe_t        strb,
  input  logic [7:0]        memRdData,
  output logic [3:0]        bitCnt,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] addrCnt
);

  localparam int HI_W = ADDR_W - 8;

  logic [7:0]        txShift;
  logic [HI_W-1:0]   hiByte;
  logic [ADDR_W-1:0] nextPage;
  logic [ADDR_W-1:0] nextWrap;

  assign nextWrap = addrCnt + 1'b1;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flatPage
      assign nextPage = nextWrap;
    end else begin : g_splitPage
      logic [PAGE_W-1:0] lowNext;
      assign lowNext  = addrCnt[PAGE_W-1:0] + 1'b1;
      assign nextPage = {addrCnt[ADDR_W-1:PAGE_W], lowNext};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.clrBits) begin
      bitCnt <= '0;
    end else if (bitEv) begin
      bitCnt <= (bitCnt == 4'd8) ? 4'd0 : bitCnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (bitEv && (bitCnt < 4'd8) && !strb.clrBits) begin
      rxByte <= {rxByte[6:0], sdaIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'hFF;
    end else if (strb.loadTx) begin
      txShift <= memRdData;
    end else if (bitEv && strb.txMode && (bitCnt < 4'd8)) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiByte <= '0;
    end else if (strb.loadHi) begin
      hiByte <= rxByte[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else if (strb.loadAddr) begin
      addrCnt <= {hiByte, rxByte};
    end else if (strb.incPage) begin
      addrCnt <= nextPage;
    end else if (strb.incWrap) begin
      addrCnt <= nextWrap;
    end
  end

  assign txBit = txShift[7];

endmodule

// File: rtl/ee_proto_ctl.sv
module ee_proto_ctl
  import ee_ctl_pkg::*;
#(
  parameter int         WR_CYCLES = 200,
  parameter logic [3:0] DEV_CODE  = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       bitEv,
  input  logic       sdaIn,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output ctlStrobe_t strb,
  output ctlState_t  state,
  output logic       busy,
  output logic       sdaLowEn,
  output logic       memRdEn,
  output logic       memWrEn
);

  localparam int BW = $clog2(WR_CYCLES + 1);

  logic          fetchReq;
  logic          fetchDly;
  logic          wrPending;
  logic [BW-1:0] busyCnt;
  logic          ackSlot;
  logic          ackNow;
  logic          slotEnd;
  logic          driveData;

  assign busy    = (busyCnt != '0);
  assign ackSlot = (bitCnt == 4'd8);
  assign slotEnd = bitEv && ackSlot && !startEv && !stopEv;

  always_comb begin
    case (state)
      ST_DEV:                  ackNow = (rxByte[7:4] == DEV_CODE) && !busy;
      ST_AHI, ST_ALO, ST_WDAT: ackNow = 1'b1;
      default:                 ackNow = 1'b0;
    endcase
  end

  assign driveData = (state == ST_RDAT) && (bitCnt < 4'd8) && !txBit
                     && !fetchReq && !fetchDly;
  assign sdaLowEn  = (ackSlot && ackNow) || driveData;
  assign memRdEn   = fetchReq;
  assign memWrEn   = slotEnd && (state == ST_WDAT);

  always_comb begin
    strb         = '0;
    strb.txMode  = (state == ST_RDAT);
    strb.loadTx  = fetchDly;
    strb.incWrap = fetchDly;
    if (startEv || stopEv) begin
      strb.clrBits = 1'b1;
    end else if (bitEv && ackSlot) begin
      case (state)
        ST_AHI:  strb.loadHi   = 1'b1;
        ST_ALO:  strb.loadAddr = 1'b1;
        ST_WDAT: strb.incPage  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fetchReq  <= 1'b0;
      fetchDly  <= 1'b0;
      wrPending <= 1'b0;
      busyCnt   <= '0;
    end else begin
      fetchDly <= fetchReq;
      fetchReq <= 1'b0;
      if (busy) busyCnt <= busyCnt - 1'b1;
      if (startEv) begin
        state <= ST_DEV;
      end else if (stopEv) begin
        state     <= ST_IDLE;
        wrPending <= 1'b0;
        if (wrPending) busyCnt <= BW'(WR_CYCLES);
      end else if (slotEnd) begin
        case (state)
          ST_DEV: begin
            if (!ackNow) begin
              state <= ST_SKIP;
            end else if (rxByte[0]) begin
              state    <= ST_RDAT;
              fetchReq <= 1'b1;
            end else begin
              state <= ST_AHI;
            end
          end
          ST_AHI:  state <= ST_ALO;
          ST_ALO:  state <= ST_WDAT;
          ST_WDAT: wrPending <= 1'b1;
          ST_RDAT: begin
            if (!sdaIn) fetchReq <= 1'b1;
            else        state    <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ee_slave_ctl.sv
module ee_slave_ctl
  import ee_ctl_pkg::*;
#(
  parameter int         ADDR_W    = 14,
  parameter int         PAGE_W    = 6,
  parameter int         WR_CYCLES = 200,
  parameter logic [3:0] DEV_CODE  = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              bitEv,
  input  logic              sdaIn,
  output logic              sdaLowEn,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData
);

  ctlStrobe_t        strb;
  ctlState_t         ctlState;
  logic              busy;
  logic [3:0]        bitCnt;
  logic [7:0]        rxByte;
  logic              txBit;
  logic [ADDR_W-1:0] addrCnt;

  ee_proto_ctl #(
    .WR_CYCLES(WR_CYCLES),
    .DEV_CODE (DEV_CODE)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .startEv (startEv),
    .stopEv  (stopEv),
    .bitEv   (bitEv),
    .sdaIn   (sdaIn),
    .bitCnt  (bitCnt),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .strb    (strb),
    .state   (ctlState),
    .busy    (busy),
    .sdaLowEn(sdaLowEn),
    .memRdEn (memRdEn),
    .memWrEn (memWrEn)
  );

  ee_addr_path #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .bitEv    (bitEv),
    .sdaIn    (sdaIn),
    .strb     (strb),
    .memRdData(memRdData),
    .bitCnt   (bitCnt),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .addrCnt  (addrCnt)
  );

  assign memAddr   = addrCnt;
  assign memWrData = rxByte;

endmodule

// File: rtl/ee_slave_chk.sv
module ee_slave_chk
  import ee_ctl_pkg::*;
#(
  parameter int         ADDR_W   = 14,
  parameter int         PAGE_W   = 6,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input logic              clk,
  input logic              rstN,
  input logic              startEv,
  input logic              stopEv,
  input logic              sdaLowEn,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input ctlState_t         ctlState,
  input logic              busy,
  input logic [3:0]        bitCnt,
  input logic [7:0]        rxByte,
  input logic [ADDR_W-1:0] addrCnt
);

  // R1
  dev_match_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_DEV && bitCnt == 4'd8 && sdaLowEn) |-> (rxByte[7:4] == DEV_CODE));

  // R4
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_DEV && bitCnt == 4'd8 && busy) |-> !sdaLowEn);

  // R3
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> ((addrCnt[PAGE_W-1:0] == PAGE_W'($past(memAddr[PAGE_W-1:0]) + 1'b1))
                 && (addrCnt[ADDR_W-1:PAGE_W] == $past(memAddr[ADDR_W-1:PAGE_W]))));

  // R9
  release_on_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startEv || stopEv) |=> !sdaLowEn);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

endmodule

bind ee_slave_ctl ee_slave_chk #(
  .ADDR_W  (ADDR_W),
  .PAGE_W  (PAGE_W),
  .DEV_CODE(DEV_CODE)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startEv (startEv),
  .stopEv  (stopEv),
  .sdaLowEn(sdaLowEn),
  .memRdEn (memRdEn),
  .memWrEn (memWrEn),
  .memAddr (memAddr),
  .ctlState(ctlState),
  .busy    (busy),
  .bitCnt  (bitCnt),
  .rxByte  (rxByte),
  .addrCnt (addrCnt)
);

// File: tb/sim_ee_slave_ctl.sv
module sim_ee_slave_ctl;

  localparam int WR_CYC = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startEv = 1'b0;
  logic        stopEv = 1'b0;
  logic        bitEv = 1'b0;
  logic        sdaIn = 1'b1;
  logic        sdaLowEn;
  logic        memRdEn;
  logic        memWrEn;
  logic [13:0] memAddr;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData = 8'h00;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  int    expQ[$];
  string tagQ[$];
  int    obsQ[$];
  logic [7:0] mem [int];

  always #10 clk = ~clk;

  ee_slave_ctl #(.WR_CYCLES(WR_CYC)) u0 (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .bitEv(bitEv), .sdaIn(sdaIn), .sdaLowEn(sdaLowEn), .memRdEn(memRdEn),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData)
  );

  // array model with registered read
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'h00;
    if (memWrEn) mem[int'(memAddr)] = memWrData;
  end

  task automatic expect_item(string tag, int val);
    tagQ.push_back(tag);
    expQ.push_back(val);
  endtask

  task automatic observe(int val);
    obsQ.push_back(val);
  endtask

  // monitor: compares observed items against expectations in order
  initial begin
    forever begin
      wait (obsQ.size() > 0);
      begin
        int o;
        o = obsQ.pop_front();
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL unexpected item: actual %0h expected none", o);
        end else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (o != e) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", t, o, e);
          end
        end
      end
    end
  end

  task automatic gap();
    repeat (6) @(negedge clk);
  endtask

  task automatic doStart();
    @(negedge clk) startEv = 1'b1;
    @(negedge clk) startEv = 1'b0;
    gap();
  endtask

  task automatic doStop();
    @(negedge clk) stopEv = 1'b1;
    @(negedge clk) stopEv = 1'b0;
    gap();
  endtask

  task automatic sendBit(bit b);
    @(negedge clk);
    sdaIn = b;
    bitEv = 1'b1;
    @(negedge clk) bitEv = 1'b0;
    sdaIn = 1'b1;
    gap();
  endtask

  // master sends a byte; slave ack observed in slot 9
  task automatic sendByte(string tag, logic [7:0] b, bit expAck);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    expect_item(tag, int'(expAck));
    observe(int'(sdaLowEn));
    sendBit(1'b1);
  endtask

  // master receives a byte and answers with mAck (1 = acknowledge)
  task automatic recvByte(string tag, logic [7:0] expv, bit mAck);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      v[i] = ~sdaLowEn;
      sendBit(1'b1);
    end
    expect_item(tag, int'(expv));
    observe(int'(v));
    sendBit(!mAck);
  endtask

  // n bits during which the slave must never pull low
  task automatic quietBits(string tag, int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      if (sdaLowEn) seen++;
      sendBit(1'b0);
      if (sdaLowEn) seen++;
    end
    expect_item(tag, 0);
    observe(seen);
  endtask

  task automatic loadAddr(string tag, logic [13:0] a);
    doStart();
    sendByte({tag, " dev wr"}, 8'hA0, 1'b1);
    sendByte({tag, " addr hi"}, {2'b00, a[13:8]}, 1'b1);
    sendByte({tag, " addr lo"}, a[7:0], 1'b1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    mem[0]       = 8'h3C;
    mem[1]       = 8'h00;
    mem[32'h41]  = 8'h5D;
    mem[32'h80]  = 8'h77;
    mem[32'h3FFF] = 8'hE1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    expect_item("R10 reset outputs", 0);
    observe(int'({sdaLowEn, memRdEn, memWrEn}));

    // R10 R6 current-address read from reset counter 0
    doStart();
    sendByte("R1 R10 dev rd ack", 8'hA1, 1'b1);
    recvByte("R10 R6 data at 0", 8'h3C, 1'b0);
    doStop();

    // R2 R3 write across page end: 0x7E, 0x7F, then wraps to 0x40
    loadAddr("R2", 14'h007E);
    sendByte("R3 data0 ack", 8'h11, 1'b1);
    sendByte("R3 data1 ack", 8'h22, 1'b1);
    sendByte("R3 data2 ack", 8'h33, 1'b1);
    doStop();

    // R4 busy: no ack
    doStart();
    sendByte("R4 busy nack", 8'hA1, 1'b0);
    doStop();
    repeat (WR_CYC + 20) @(negedge clk);

    // R4 R6 after busy: ack; counter is 0x41
    doStart();
    sendByte("R4 post busy ack", 8'hA1, 1'b1);
    recvByte("R6 after write", 8'h5D, 1'b0);
    doStop();

    // R3 page wrap stored at 0x40
    expect_item("R3 array 0x40", 8'h33);
    observe(int'(mem[32'h40]));

    // R7 R8 R5 random then sequential read across page boundary
    loadAddr("R7", 14'h007E);
    doStart();
    sendByte("R7 dev rd ack", 8'hA1, 1'b1);
    recvByte("R7 data 0x7E", 8'h11, 1'b1);
    recvByte("R8 data 0x7F", 8'h22, 1'b1);
    recvByte("R5 data 0x80", 8'h77, 1'b0);
    quietBits("R8 released after nack", 9);
    doStop();

    // R7 no busy after address-only write: immediate ack
    doStart();
    sendByte("R7 no busy ack", 8'hA1, 1'b1);
    recvByte("R6 after read", 8'h00, 1'b0);
    doStop();

    // R5 whole-array rollover
    loadAddr("R5", 14'h3FFF);
    doStart();
    sendByte("R5 dev rd ack", 8'hA1, 1'b1);
    recvByte("R5 data 0x3FFF", 8'hE1, 1'b1);
    recvByte("R5 rollover 0x0", 8'h3C, 1'b0);
    doStop();

    // R1 wrong code, middle bits ignored
    doStart();
    sendByte("R1 wrong code nack", 8'hB0, 1'b0);
    quietBits("R1 quiet after mismatch", 9);
    doStop();
    doStart();
    sendByte("R1 middle bits ignored", 8'hAE, 1'b1);
    doStop();

    // R9 stop inside driven byte (counter is 1, data 0x00)
    doStart();
    sendByte("R9 dev rd ack", 8'hA1, 1'b1);
    expect_item("R9 driving before stop", 1);
    observe(int'(sdaLowEn));
    sendBit(1'b1);
    sendBit(1'b1);
    doStop();
    expect_item("R9 released after stop", 0);
    observe(int'(sdaLowEn));

    repeat (4) @(negedge clk);
    wait (obsQ.size() == 0);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL leftover expectations: actual %0d expected 0", expQ.size());
    end
    finishRun();
  end

endmodule